// File: doc/BRIEF.md
# Interrupt Request Capture Front-End

This block sits between a group of active-high interrupt request lines and a fixed-priority resolver. Each line is qualified individually: in level mode a high line counts as a request, and in edge mode only a low-to-high change arms the line. The qualified state appears on a pending vector, and a request flag goes to the processor side.

The pending vector is transparent in normal operation. It follows the qualified lines in the same cycle, so a request that drops away before acknowledge also disappears from the output. An acknowledge sequence freezes the vector. The freeze begins at the first falling edge of an active-low acknowledge strobe and ends when the strobe rises while the last-pulse indication is high.

At the first falling edge, only the pending bit with the lowest index is cleared, and its index is reported. An edge-mode line that has been acknowledged stays quiet until it goes low and then high again. A level-mode line that is still high requests again as soon as the freeze ends. If nothing is pending when acknowledge arrives, a one-cycle spurious pulse is raised and the highest index is reported.

Top module: `irqf_capture`

## Requirements
- R1: During and right after reset, with all lines low, pending_o is 0, req_o is 0, ack_idx_o is 0 and spurious_o is 0.
- R2: With mode bit 1 (level), pending_o[i] equals irq_i[i] in the same cycle while not frozen.
- R3: With mode bit 0 (edge), a line that rises from low sets pending_o[i] in the same cycle, and pending_o[i] stays set while the line stays high.
- R4: Outside freeze, a line that drops clears its pending bit in the same cycle, whatever its mode.
- R5: req_o is the OR of pending_o while not frozen, and it is 0 during freeze.
- R6: A first falling edge is a cycle in which ack_n_i is 0, ack_n_i was 1 at the previous clock edge, and no freeze is active. Freeze is active from the next cycle until the clock edge after a cycle in which ack_n_i rises with ack_last_i high. While freeze is active, pending_o holds its latched value whatever the lines do.
- R7: At a first falling edge, only the lowest-index pending bit is cleared (line 0 has the highest priority). From the next cycle, ack_idx_o gives that bit's index.
- R8: An acknowledged edge-mode line does not request again while it stays high. It requests again only after it has been low for at least one cycle and then rises.
- R9: A level-mode line that is still high after the freeze ends shows as pending again.
- R10: If nothing is pending at a first falling edge, spurious_o is 1 for exactly one cycle and ack_idx_o is NUM_LINES-1 (7). This includes a line that dropped before that edge.
- R11: Further falling edges of ack_n_i inside the freeze clear no further bits and do not change ack_idx_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NUM_LINES | Active-high request lines |
| level_mode_i | input | NUM_LINES | Per-line trigger mode, 1 = level, 0 = edge |
| ack_n_i | input | 1 | Active-low acknowledge strobe |
| ack_last_i | input | 1 | High during the last acknowledge pulse |
| pending_o | output | NUM_LINES | Pending request vector to the resolver |
| req_o | output | 1 | Request flag towards the processor |
| ack_idx_o | output | IDX_W | Index of the bit cleared at acknowledge |
| spurious_o | output | 1 | One-cycle pulse when acknowledge finds nothing pending |

## Verification
The assertions assume that all inputs are synchronous to clk. They also assume that ack_last_i is only meaningful when ack_n_i rises, and that the mode bits do not change while a line is being acknowledged. The stimulus drives every input on the falling clock edge. It changes the mode bits only between scenarios, when no freeze is active and all lines are low. It also ends every acknowledge sequence with a rising strobe while ack_last_i is high.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_mode_e;

   function automatic int unsigned idx_bits(int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/irqf_line_qual.sv
module irqf_line_qual
   import irqf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic mode_i,
   input  logic clr_i,
   output logic qual_o
);
   logic line_q;
   logic seen_q;
   logic edge_qual;

   // seen_q remembers a rise since the line was last low; an acknowledge
   // clears it and only a return to low can re-arm the detector
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= 1'b0;
         seen_q <= 1'b0;
      end else begin
         line_q <= line_i;
         if (line_i)
            seen_q <= (seen_q | ~line_q) & ~clr_i;
         else
            seen_q <= 1'b0;
      end
   end

   assign edge_qual = line_i & (seen_q | ~line_q);
   assign qual_o    = (trig_mode_e'(mode_i) == TRIG_LEVEL) ? line_i : edge_qual;

   // R8: an acknowledged edge line stays quiet while it is held high
   p_edge_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && line_i && !mode_i) |=> (!line_i || mode_i || !qual_o));
endmodule

// File: rtl/irqf_prio_enc.sv
module irqf_prio_enc #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned IW    = 3
) (
   input  logic [WIDTH-1:0] req_i,
   output logic [WIDTH-1:0] grant_o,
   output logic [IW-1:0]    idx_o,
   output logic             any_o
);
   logic [WIDTH:0] taken;

   assign taken[0] = 1'b0;

   for (genvar g = 0; g < WIDTH; g++) begin : g_chain
      assign grant_o[g]  = req_i[g] & ~taken[g];
      assign taken[g+1]  = taken[g] | req_i[g];
   end

   assign any_o = taken[WIDTH];

   always_comb begin
      idx_o = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (grant_o[i]) idx_o = IW'(i);
      end
   end

   // R7: at most one line wins
   always_comb begin
      p_grant_onehot_r7: assert ($onehot0(grant_o));
   end
endmodule

// File: rtl/irqf_ack_seq.sv
module irqf_ack_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_n_i,
   input  logic ack_last_i,
   output logic first_fall_o,
   output logic freeze_o
);
   logic ack_q;
   logic freeze_q;
   logic end_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q    <= 1'b1;
         freeze_q <= 1'b0;
      end else begin
         ack_q <= ack_n_i;
         if (first_fall_o)
            freeze_q <= 1'b1;
         else if (end_rise)
            freeze_q <= 1'b0;
      end
   end

   assign first_fall_o = ack_q & ~ack_n_i & ~freeze_q;
   assign end_rise     = ~ack_q & ack_n_i & ack_last_i & freeze_q;
   assign freeze_o     = freeze_q;

   // R6: freeze only opens after a low strobe was sampled
   p_freeze_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(freeze_o) |-> !$past(ack_n_i));
   // R11: inside freeze a new falling strobe is never a first fall
   p_no_refall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_o && $past(freeze_o) && !ack_n_i) |-> !first_fall_o);
endmodule

// File: rtl/irqf_capture.sv
module irqf_capture #(
   parameter int unsigned NUM_LINES = 8,
   localparam int unsigned IDX_W = irqf_pkg::idx_bits(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_i,
   input  logic [NUM_LINES-1:0] level_mode_i,
   input  logic                 ack_n_i,
   input  logic                 ack_last_i,
   output logic [NUM_LINES-1:0] pending_o,
   output logic                 req_o,
   output logic [IDX_W-1:0]     ack_idx_o,
   output logic                 spurious_o
);
   localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(NUM_LINES - 1);

   initial begin
      if (NUM_LINES < 2 || NUM_LINES > 32)
         $fatal(1, "irqf_capture: NUM_LINES out of range");
   end

   logic [NUM_LINES-1:0] qual;
   logic [NUM_LINES-1:0] grant;
   logic [NUM_LINES-1:0] clr_vec;
   logic [NUM_LINES-1:0] frz_vec;
   logic [IDX_W-1:0]     win_idx;
   logic [IDX_W-1:0]     idx_q;
   logic                 any_req;
   logic                 first_fall;
   logic                 freeze;
   logic                 spur_q;

   assign clr_vec = grant & {NUM_LINES{first_fall}};

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      irqf_line_qual u_qual (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (irq_i[g]),
         .mode_i (level_mode_i[g]),
         .clr_i  (clr_vec[g]),
         .qual_o (qual[g])
      );
   end

   irqf_prio_enc #(
      .WIDTH (NUM_LINES),
      .IW    (IDX_W)
   ) u_prio (
      .req_i   (qual),
      .grant_o (grant),
      .idx_o   (win_idx),
      .any_o   (any_req)
   );

   irqf_ack_seq u_ack (
      .clk          (clk),
      .rst_n        (rst_n),
      .ack_n_i      (ack_n_i),
      .ack_last_i   (ack_last_i),
      .first_fall_o (first_fall),
      .freeze_o     (freeze)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frz_vec <= '0;
         idx_q   <= '0;
         spur_q  <= 1'b0;
      end else begin
         spur_q <= 1'b0;
         if (first_fall) begin
            frz_vec <= qual & ~grant;
            idx_q   <= any_req ? win_idx : SPUR_IDX;
            spur_q  <= ~any_req;
         end
      end
   end

   assign pending_o  = freeze ? frz_vec : qual;
   assign req_o      = (|pending_o) & ~freeze;
   assign ack_idx_o  = idx_q;
   assign spurious_o = spur_q;

   // R6: the frozen vector does not move
   p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && $past(freeze)) |-> $stable(pending_o));
   // R7: exactly one bit leaves the vector at a real acknowledge
   p_single_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(freeze) && !spurious_o) |->
         ($countones(pending_o) + 1 == $countones($past(qual))));
   // R10: a spurious acknowledge reports the last index
   p_spur_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
      spurious_o |-> (ack_idx_o == SPUR_IDX));
   // R10: the spurious flag lasts one cycle
   p_spur_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      spurious_o |=> !spurious_o);
endmodule

// File: tb/irqf_capture_test.sv
module irqf_capture_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq = '0;
   logic [7:0] lvl = '0;
   logic       ack_n = 1'b1;
   logic       ack_last = 1'b0;
   logic [7:0] pend;
   logic       req;
   logic [2:0] idx;
   logic       spur;
   int         total = 0;
   int         bad = 0;

   always #5 clk = ~clk;

   irqf_capture #(.NUM_LINES(8)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .irq_i        (irq),
      .level_mode_i (lvl),
      .ack_n_i      (ack_n),
      .ack_last_i   (ack_last),
      .pending_o    (pend),
      .req_o        (req),
      .ack_idx_o    (idx),
      .spurious_o   (spur)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // drive on falling edge, sample 2 ns later
   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic settle();
      #2;
   endtask

   task automatic end_freeze();
      nxt();
      ack_n = 1'b1;
      ack_last = 1'b1;
      nxt();
      ack_last = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) nxt();
      settle();
      chk("R1 pending", pend, 0);
      chk("R1 req", req, 0);
      chk("R1 idx", idx, 0);
      chk("R1 spur", spur, 0);
      nxt();
      rst_n = 1'b1;
      nxt();
      settle();
      chk("R1 pending after release", pend, 0);
   endtask

   task automatic t_level();
      lvl = 8'hFF;
      nxt();
      irq = 8'h08;
      settle();
      chk("R2 level follows", pend, 8'h08);
      chk("R5 req high", req, 1);
      nxt();
      irq = 8'h00;
      settle();
      chk("R4 level drop", pend, 8'h00);
      chk("R5 req low", req, 0);
   endtask

   task automatic t_edge();
      lvl = 8'h00;
      nxt();
      irq = 8'h20;
      settle();
      chk("R3 edge sets", pend, 8'h20);
      nxt();
      settle();
      chk("R3 edge holds", pend, 8'h20);
      nxt();
      irq = 8'h00;
      settle();
      chk("R4 edge drop", pend, 8'h00);
   endtask

   task automatic t_ack();
      lvl = 8'hFF;
      nxt();
      irq = 8'h14;
      nxt();
      ack_n = 1'b0;
      settle();
      chk("R6 not frozen yet", pend, 8'h14);
      nxt();
      settle();
      chk("R7 one bit cleared", pend, 8'h10);
      chk("R7 index", idx, 2);
      chk("R5 req low in freeze", req, 0);
      chk("R10 no spur", spur, 0);
      irq = 8'h00;
      settle();
      chk("R6 hold while lines move", pend, 8'h10);
      nxt();
      ack_n = 1'b1;
      nxt();
      ack_n = 1'b0;
      nxt();
      settle();
      chk("R11 second fall no clear", pend, 8'h10);
      chk("R11 index kept", idx, 2);
      ack_n = 1'b1;
      ack_last = 1'b1;
      settle();
      chk("R6 still frozen at rise", pend, 8'h10);
      nxt();
      ack_last = 1'b0;
      settle();
      chk("R6 transparent after", pend, 8'h00);
   endtask

   task automatic t_level_rearm();
      lvl = 8'hFF;
      nxt();
      irq = 8'h02;
      nxt();
      ack_n = 1'b0;
      nxt();
      settle();
      chk("R7 level idx", idx, 1);
      chk("R7 frozen empty", pend, 8'h00);
      end_freeze();
      settle();
      chk("R9 level again", pend, 8'h02);
      chk("R9 req again", req, 1);
      irq = 8'h00;
      nxt();
   endtask

   task automatic t_edge_rearm();
      lvl = 8'h80;
      nxt();
      irq = 8'h81;
      nxt();
      ack_n = 1'b0;
      nxt();
      settle();
      chk("R7 priority line0", idx, 0);
      chk("R7 line7 held", pend, 8'h80);
      end_freeze();
      settle();
      chk("R8 edge stays quiet", pend, 8'h80);
      nxt();
      settle();
      chk("R8 still quiet", pend, 8'h80);
      irq = 8'h80;
      nxt();
      settle();
      chk("R8 low not pending", pend, 8'h80);
      irq = 8'h81;
      settle();
      chk("R8 rearmed", pend, 8'h81);
      nxt();
      irq = 8'h00;
      nxt();
   endtask

   task automatic t_spurious();
      lvl = 8'hFF;
      nxt();
      irq = 8'h01;
      nxt();
      irq = 8'h00;
      ack_n = 1'b0;
      nxt();
      settle();
      chk("R10 spur set", spur, 1);
      chk("R10 spur idx", idx, 7);
      chk("R10 spur pending", pend, 8'h00);
      nxt();
      settle();
      chk("R10 spur one cycle", spur, 0);
      end_freeze();
   endtask

   initial begin
      t_reset();
      t_level();
      t_edge();
      t_ack();
      t_level_rearm();
      t_edge_rearm();
      t_spurious();
      repeat (2) nxt();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule